// File: doc/BRIEF.md
# Pulse-Stepped Shift Controller

This block shifts a single-length (48-bit) or double-length (two 48-bit words) operand left or right, logically or arithmetically, without a full-width barrel shifter. The operand sits in a working bank. A buffer bank holds two guard bits below its least significant end. Each externally supplied command pulse moves the value across exactly one fixed shift path: from the working bank to the buffer bank, or back again. The direction of travel alternates, and the first transfer always leaves the working bank. Counts of eight or more are covered by repeated eight-place hops until fewer than eight places remain. If an odd number of hops has left the value in the buffer bank, it comes back unshifted. Any remainder then takes one out-and-back pair of transfers: the outgoing half carries half of the remainder, rounded down, and the returning half carries the rest.

A sequencer starts an operation with a single start strobe, which loads the count, the mode bits and the operand. It then feeds the block one pulse per transfer it wants, at whatever pace it likes. The block raises a one-cycle done strobe once the count is exhausted and the value rests in the working bank. The result ports always show the working bank, unpacked according to the latched mode.

Top module: `shift_stepper`

## Requirements
- R1: After reset, busy_o and done_o are 0 and both result words read 0.
- R2: While busy_o is 0, start_i loads count_i, shl_i, dbl_i, arith_i and both operand words, and raises busy_o on the next cycle. While busy_o is 1, start_i has no effect on the result.
- R3: A transfer happens only on a cycle in which cmd_pulse_i is 1, busy_o is 1 and work remains. Pulses at any other time, including the start cycle and the cycles after done_o, change nothing.
- R4: An operation of count n takes floor(n/8) eight-place hops. It takes one extra unshifted return if that number of hops is odd, and two more transfers if n mod 8 is nonzero. If a pulse arrives on every cycle, busy_o stays high for that many transfers plus one cycle. A count of 0 finishes one cycle after start.
- R5: The first transfer leaves the working bank, transfers alternate between the two banks, and done_o is raised only when the value is in the working bank.
- R6: done_o is high for exactly one cycle, in the same cycle in which busy_o returns to 0.
- R7: With dbl_i=0, only res_hi_o is shifted; res_lo_o keeps the loaded low operand. Left shifts fill with 0. Right shifts fill with 0 when arith_i=0 and with bit 47 of the high word when arith_i=1.
- R8: With dbl_i=1 and arith_i=0, the two words act as one 96-bit value, high word above low word, and vacated places fill with 0.
- R9: With dbl_i=1 and arith_i=1, bit 47 of the low word is kept from the operand and skipped. Data moves between bit 0 of the high word and bit 46 of the low word as one 95-bit value. Right shifts replicate bit 47 of the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load a new operation when idle |
| count_i | input | 7 | Number of places to shift |
| shl_i | input | 1 | 1 = left shift, 0 = right shift |
| dbl_i | input | 1 | 1 = double length, 0 = single length |
| arith_i | input | 1 | 1 = arithmetic, 0 = logical |
| opnd_hi_i | input | 48 | High (or only) operand word |
| opnd_lo_i | input | 48 | Low operand word |
| cmd_pulse_i | input | 1 | Command pulse, one transfer each |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| res_hi_o | output | 48 | High result word |
| res_lo_o | output | 48 | Low result word |

## Verification
Two events can fall in the same cycle: the acceptance of a start and a command pulse, and the generation of done and a command pulse. Holding cmd_pulse_i high through the start cycle, the whole operation and the cycles after done provokes both. Only the pulses that do real work may move the value, so the busy length must equal the transfer count plus one, and the result must stay unchanged after done. A gapped pulse pattern with a stray start in mid-operation is judged the same way: the busy length must be twice the transfer count, and the result must be that of the first operand.

// File: rtl/shift_stepper_pkg.sv
package shift_stepper_pkg;

  // Kind of bank-to-bank move performed in a cycle.
  typedef enum logic [1:0] {
    XF_NONE = 2'd0,
    XF_OUT  = 2'd1,   // working bank -> buffer bank
    XF_BACK = 2'd2    // buffer bank -> working bank
  } xfer_e;

  // Number of command pulses an operation of n places consumes.
  function automatic int pulses_for(int n, int hop);
    int hops;
    hops = n / hop;
    return hops + (hops % 2) + (((n % hop) != 0) ? 2 : 0);
  endfunction

endpackage

// File: rtl/shift_stepper_path.sv
module shift_stepper_path #(
  parameter int  VW     = 96,
  parameter int  GUARD  = 2,
  parameter int  DIST_W = 4,
  parameter bit  TO_BUF = 1'b1,
  localparam int BW     = VW + GUARD,
  localparam int SRC_W  = TO_BUF ? VW : BW,
  localparam int DST_W  = TO_BUF ? BW : VW
) (
  input  logic [SRC_W-1:0]  src_i,
  input  logic              left_i,
  input  logic              fill_i,
  input  logic [DIST_W-1:0] dist_i,
  output logic [DST_W-1:0]  dst_o
);

  generate
    if (TO_BUF) begin : g_out
      // Value enters the buffer with GUARD zero bits appended below it.
      assign dst_o = left_i ? ({src_i, {GUARD{1'b0}}} << dist_i)
                            : BW'($signed({fill_i, src_i, {GUARD{1'b0}}}) >>> dist_i);
    end else begin : g_back
      // Guard bits are dropped on the way back to the working bank.
      assign dst_o = left_i ? VW'((src_i << dist_i) >> GUARD)
                            : VW'(($signed({fill_i, src_i}) >>> dist_i) >> GUARD);
    end
  endgenerate

endmodule

// File: rtl/shift_stepper_seq.sv
module shift_stepper_seq
  import shift_stepper_pkg::*;
#(
  parameter int  CNT_W  = 7,
  parameter int  HOP    = 8,
  localparam int DIST_W = $clog2(HOP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pulse_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output xfer_e             xfer_o,
  output logic [DIST_W-1:0] dist_o
);

  logic [CNT_W-1:0] rem_q;
  logic             in_buf_q;
  logic             pair_q;     // outgoing half of the remainder pair issued
  logic             accept_w, finished_w, step_w;
  xfer_e            plan_xf;

  assign accept_w   = start_i & ~busy_o;
  assign finished_w = busy_o & (rem_q == '0) & ~in_buf_q;
  assign step_w     = busy_o & pulse_i & ~finished_w;

  always_comb begin
    if (rem_q >= CNT_W'(HOP)) begin
      plan_xf = in_buf_q ? XF_BACK : XF_OUT;
      dist_o  = DIST_W'(HOP);
    end else if (in_buf_q) begin
      plan_xf = XF_BACK;
      dist_o  = pair_q ? DIST_W'(rem_q) : '0;
    end else begin
      plan_xf = XF_OUT;
      dist_o  = DIST_W'(rem_q >> 1);
    end
  end

  assign xfer_o = step_w ? plan_xf : XF_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      rem_q    <= '0;
      in_buf_q <= 1'b0;
      pair_q   <= 1'b0;
    end else begin
      done_o <= finished_w;
      if (accept_w) begin
        busy_o   <= 1'b1;
        rem_q    <= count_i;
        in_buf_q <= 1'b0;
        pair_q   <= 1'b0;
      end else if (finished_w) begin
        busy_o <= 1'b0;
      end else if (step_w) begin
        rem_q    <= rem_q - CNT_W'(dist_o);
        in_buf_q <= ~in_buf_q;
        pair_q   <= (plan_xf == XF_OUT) && (rem_q < CNT_W'(HOP));
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R4
  rem_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (rem_q <= $past(rem_q)));
  // R4
  hop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o != XF_NONE) |-> (dist_o <= DIST_W'(HOP)));

endmodule

// File: rtl/shift_stepper.sv
module shift_stepper
  import shift_stepper_pkg::*;
#(
  parameter int  WORD_W = 48,
  parameter int  CNT_W  = 7,
  parameter int  HOP    = 8,
  parameter int  GUARD  = 2,
  localparam int VW     = 2 * WORD_W,
  localparam int BW     = VW + GUARD,
  localparam int DIST_W = $clog2(HOP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              shl_i,
  input  logic              dbl_i,
  input  logic              arith_i,
  input  logic [WORD_W-1:0] opnd_hi_i,
  input  logic [WORD_W-1:0] opnd_lo_i,
  input  logic              cmd_pulse_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] res_hi_o,
  output logic [WORD_W-1:0] res_lo_o
);

  // Working bank is held MSB-aligned so one path pair serves every mode.
  function automatic logic [VW-1:0] pack_work(logic dbl, logic ar,
                                              logic [WORD_W-1:0] hi,
                                              logic [WORD_W-1:0] lo);
    if (!dbl)     return {hi, {WORD_W{1'b0}}};
    else if (ar)  return {hi, lo[WORD_W-2:0], 1'b0};
    else          return {hi, lo};
  endfunction

  function automatic logic [VW-1:0] unpack_work(logic dbl, logic ar,
                                                logic [VW-1:0] w,
                                                logic [WORD_W-1:0] keep);
    if (!dbl)     return {w[VW-1:WORD_W], keep};
    else if (ar)  return {w[VW-1:WORD_W], keep[WORD_W-1], w[WORD_W-1:1]};
    else          return w;
  endfunction

  logic [VW-1:0]     work_q, work_nx;
  logic [BW-1:0]     buf_q, buf_nx;
  logic [WORD_W-1:0] keep_lo_q;
  logic              left_q, dbl_q, arith_q;
  logic              accept_w;
  logic              mirror_in_buf_q;   // independent bank tracker for checks
  xfer_e             xfer_w;
  logic [DIST_W-1:0] dist_w;

  assign accept_w = start_i & ~busy_o;

  shift_stepper_seq #(.CNT_W(CNT_W), .HOP(HOP)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .pulse_i (cmd_pulse_i),
    .count_i (count_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .xfer_o  (xfer_w),
    .dist_o  (dist_w)
  );

  shift_stepper_path #(.VW(VW), .GUARD(GUARD), .DIST_W(DIST_W), .TO_BUF(1'b1)) u_out (
    .src_i  (work_q),
    .left_i (left_q),
    .fill_i (arith_q & work_q[VW-1]),
    .dist_i (dist_w),
    .dst_o  (buf_nx)
  );

  shift_stepper_path #(.VW(VW), .GUARD(GUARD), .DIST_W(DIST_W), .TO_BUF(1'b0)) u_back (
    .src_i  (buf_q),
    .left_i (left_q),
    .fill_i (arith_q & buf_q[BW-1]),
    .dist_i (dist_w),
    .dst_o  (work_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q          <= '0;
      buf_q           <= '0;
      keep_lo_q       <= '0;
      left_q          <= 1'b0;
      dbl_q           <= 1'b0;
      arith_q         <= 1'b0;
      mirror_in_buf_q <= 1'b0;
    end else if (accept_w) begin
      work_q          <= pack_work(dbl_i, arith_i, opnd_hi_i, opnd_lo_i);
      buf_q           <= '0;
      keep_lo_q       <= opnd_lo_i;
      left_q          <= shl_i;
      dbl_q           <= dbl_i;
      arith_q         <= arith_i;
      mirror_in_buf_q <= 1'b0;
    end else if (xfer_w == XF_OUT) begin
      buf_q           <= buf_nx;
      mirror_in_buf_q <= 1'b1;
    end else if (xfer_w == XF_BACK) begin
      work_q          <= work_nx;
      mirror_in_buf_q <= 1'b0;
    end
  end

  assign {res_hi_o, res_lo_o} = unpack_work(dbl_q, arith_q, work_q, keep_lo_q);

  // R3
  pulse_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_w != XF_NONE) |-> cmd_pulse_i);
  // R5
  out_from_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_w == XF_OUT) |-> !mirror_in_buf_q);
  // R5
  back_from_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_w == XF_BACK) |-> mirror_in_buf_q);
  // R5
  done_in_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mirror_in_buf_q);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> ($stable(keep_lo_q) && $stable(left_q) && $stable(dbl_q)));

endmodule

// File: tb/shift_stepper_test.sv
`timescale 1ns/1ps
module shift_stepper_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  count_i = '0;
  logic        shl_i = 1'b0, dbl_i = 1'b0, arith_i = 1'b0;
  logic [47:0] opnd_hi_i = '0, opnd_lo_i = '0;
  logic        cmd_pulse_i = 1'b0;
  logic        busy_o, done_o;
  logic [47:0] res_hi_o, res_lo_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  shift_stepper uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .shl_i(shl_i), .dbl_i(dbl_i), .arith_i(arith_i),
    .opnd_hi_i(opnd_hi_i), .opnd_lo_i(opnd_lo_i), .cmd_pulse_i(cmd_pulse_i),
    .busy_o(busy_o), .done_o(done_o), .res_hi_o(res_hi_o), .res_lo_o(res_lo_o)
  );

  typedef struct {
    logic [95:0] res;
    int          blen;
    string       tag;
    bit          poke;
  } exp_t;

  exp_t sb[$];

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected result, written from the mode descriptions.
  function automatic logic [95:0] model(bit left, bit dbl, bit ar, int n,
                                        logic [47:0] hi, logic [47:0] lo);
    if (!dbl) begin
      logic [47:0] r;
      if (left)    r = hi << n;
      else if (ar) r = $signed(hi) >>> n;
      else         r = hi >> n;
      return {r, lo};
    end else if (!ar) begin
      logic [95:0] v;
      v = {hi, lo};
      return left ? (v << n) : (v >> n);
    end else begin
      logic signed [94:0] m;
      m = {hi, lo[46:0]};
      m = left ? (m <<< n) : (m >>> n);
      return {m[94:47], lo[47], m[46:0]};
    end
  endfunction

  function automatic int transfers(int n);
    int k;
    k = 0;
    while (n >= 8) begin n -= 8; k++; end
    if (k % 2 == 1) k++;
    if (n > 0) k += 2;
    return k;
  endfunction

  // Driver: pushes the expectation, then starts and paces the pulses.
  task automatic run(bit left, bit dbl, bit ar, int n, logic [47:0] hi,
                     logic [47:0] lo, bit cont, bit poke);
    exp_t e;
    int   k;
    int   t;
    k      = transfers(n);
    e.res  = model(left, dbl, ar, n, hi, lo);
    e.blen = cont ? k + 1 : ((k == 0) ? 1 : 2 * k);
    e.tag  = dbl ? (ar ? "R9" : "R8") : "R7";
    e.poke = poke;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b1; count_i = 7'(n); shl_i = left; dbl_i = dbl; arith_i = ar;
    opnd_hi_i = hi; opnd_lo_i = lo;
    cmd_pulse_i = cont;            // a pulse in the start cycle must do nothing
    t = 1;
    while (t < 400) begin
      @(negedge clk);
      start_i = 1'b0;
      if (done_o) break;
      cmd_pulse_i = cont ? 1'b1 : t[0];
      if (poke && t == 2) begin    // stray start in mid-operation
        start_i = 1'b1; count_i = 7'd3; shl_i = ~left; dbl_i = ~dbl;
        opnd_hi_i = ~hi; opnd_lo_i = ~lo;
      end
      t++;
    end
    cmd_pulse_i = 1'b1;            // pulses after done must do nothing
    repeat (3) @(negedge clk);
    cmd_pulse_i = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops and compares on every done strobe.
  initial begin
    int          bcnt;
    int          hold;
    logic [95:0] last;
    bcnt = 0; hold = 0; last = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy_o) bcnt++;
        if (done_o) begin
          if (sb.size() == 0) begin
            chk("R6", 96'd1, 96'd0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, {res_hi_o, res_lo_o}, e.res);
            if (e.poke) chk("R2", {res_hi_o, res_lo_o}, e.res);
            chk("R4 R5 R3 busy length", 96'(bcnt), 96'(e.blen));
            chk("R6 busy low with done", 96'(busy_o), 96'd0);
          end
          last = {res_hi_o, res_lo_o};
          bcnt = 0;
          hold = 3;
        end else if (hold > 0) begin
          if (hold == 3) chk("R6 single-cycle done", 96'(done_o), 96'd0);
          hold--;
          if (hold == 0) chk("R3 idle pulses", {res_hi_o, res_lo_o}, last);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 busy", 96'(busy_o), 96'd0);
    chk("R1 done", 96'(done_o), 96'd0);
    chk("R1 result", {res_hi_o, res_lo_o}, 96'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(1, 0, 0, 0,   48'h0123_4567_89AB, 48'h0F0F_0F0F_0F0F, 1, 0);
    run(1, 0, 0, 5,   48'h8123_4567_89AB, 48'h1111_2222_3333, 1, 0);
    run(0, 0, 1, 13,  48'hF000_0000_1234, 48'h5555_5555_5555, 1, 0);
    run(0, 0, 0, 16,  48'hF0E1_D2C3_B4A5, 48'hAAAA_0000_BBBB, 0, 0);
    run(0, 0, 1, 8,   48'h8000_0000_00FF, 48'h0000_0000_0001, 1, 0);
    run(1, 1, 0, 45,  48'h1234_5678_9ABC, 48'hDEF0_1357_9BDF, 0, 1);
    run(0, 1, 1, 50,  48'h9876_5432_10FE, 48'hFFFF_0000_FFFF, 1, 0);
    run(1, 1, 1, 3,   48'h0000_0000_0001, 48'hC000_0000_0005, 1, 0);
    run(0, 1, 0, 95,  48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 1, 0);
    run(0, 0, 1, 60,  48'hA5A5_A5A5_A5A5, 48'h0000_0000_0000, 1, 0);
    run(0, 1, 1, 127, 48'h8000_0000_0000, 48'h7FFF_FFFF_FFFF, 1, 0);
    run(0, 0, 1, 1,   48'h8000_0000_0003, 48'h0000_1111_0000, 0, 0);
    run(0, 1, 1, 7,   48'h0000_0000_00FF, 48'h8000_0000_0000, 0, 0);

    repeat (5) @(negedge clk);
    if (sb.size() != 0) chk("R6 pending items", 96'(sb.size()), 96'd0);
    finish_run();
  end

endmodule